// File: doc/BRIEF.md
# Bus Address Watchpoint Unit

This block watches a processor's bus and stops the processor when an access lands in a watched region. It holds a table of watch entries. Each entry has a start address, a length in bytes, and a kind made of three flags: stop on read, stop on write, and keep armed after a hit. Every bus cycle is compared against every armed entry in parallel.

When an access falls inside an armed window and its direction matches that entry's flags, a halt request is raised on the next clock. The request stays high until the debugger pulses the clear input. Each entry also has a hit flag, which is set on any access inside its window in either direction. An entry whose keep-armed flag is clear disarms itself after any access inside its window.

A debugger programs entries through a simple write port and replaces the whole arm map in a single write. An allocate port supports a "step over a subroutine call" action. It always shows the lowest free entry index, and on request it arms that entry as a one-byte read watch at the given program counter plus three.

Halt control is a two-state machine:
- ST_RUN → ST_HALT when a direction-matching access arrives.
- ST_HALT → ST_RUN on a clear pulse, unless a new match arrives in the same cycle.

Top module: `wpu_watch_unit`

## Requirements
- R1: Out of reset, `halt_o` is 0, `en_map_o` is all zeros, `hit_o` is all zeros, and `alloc_idx_o` is 0.
- R2: An armed entry's window holds every address A with base <= A < base + size. The sum is taken one bit wider than the address, so a window ending at the top of the address space does not wrap. A size of 0 matches nothing.
- R3: The kind field encodes bit0 = stop on read, bit1 = stop on write, bit2 = keep armed. A valid bus cycle inside a window requests a halt only if the bit for its direction is set (`bus_write` 0 = read, 1 = write).
- R4: Any valid bus cycle inside an armed window sets that entry's bit in `hit_o`, whatever the direction. Writing the entry through the config port or the allocate port clears its hit bit.
- R5: An armed entry with kind bit2 = 0 is disarmed (its `en_map_o` bit clears) on the clock after any valid cycle inside its window, in either direction.
- R6: All armed entries are checked on every cycle. Several entries can record hits and disarm in the same cycle.
- R7: An entry whose arm bit is 0 never records a hit, never disarms, and never requests a halt.
- R8: `halt_o` rises on the clock edge that samples the matching bus cycle. It stays high until `halt_clr` is sampled high. A match in the same cycle as `halt_clr` keeps it high.
- R9: `alloc_idx_o` shows, without a clock, the lowest entry index whose arm bit is 0, or 0xFF when every entry is armed. A request made while the value is 0xFF changes nothing.
- R10: When `alloc_req` is sampled and a free entry exists, that entry becomes a kind-001 (read, not kept armed), size-1 watch at `alloc_pc` + 3, and it is armed on the same edge.
- R11: The next arm map is built in three steps: start from `en_wdata` if `en_we` is high, else from the current map; then clear the entries disarmed by R5; then set the allocated entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one entry |
| cfg_idx | input | $clog2(N) | Entry to write |
| cfg_base | input | ADDR_W | Window start address |
| cfg_size | input | SIZE_W | Window length in bytes |
| cfg_kind | input | 3 | Kind flags: bit0 read, bit1 write, bit2 keep armed |
| en_we | input | 1 | Replace the arm map |
| en_wdata | input | N | New arm map |
| alloc_req | input | 1 | Allocate a one-byte read watch |
| alloc_pc | input | ADDR_W | Program counter used for the allocated watch |
| alloc_idx_o | output | 8 | Lowest free entry index, or 0xFF when all are armed |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | ADDR_W | Bus address |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| halt_clr | input | 1 | Pulse to release the halt request |
| halt_o | output | 1 | Registered halt request |
| en_map_o | output | N | Current arm map |
| hit_o | output | N | Per-entry hit flags |

## Verification
The bench probes the addresses just outside a window: the last byte and the first excluded byte, the byte below the base, a window ending at 0xFFFF, and a zero-length window. An off-by-one or wrapping compare would stop on the excluded byte, or miss the top one.

It sends a write into a read-only window. A design that ties hit flags to the direction would leave the flag clear; one that ignores the direction would halt.

It also covers overlapping windows hit in one cycle, a match that arrives together with a clear, and an arm-map write that collides with a self-disarm. A wrong priority shows up as a dropped halt or an entry left armed.

Allocation is checked with a partly used table and with a full one. A full table must leave the map untouched.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
    // bit2 keep armed, bit1 stop on write, bit0 stop on read
    typedef struct packed {
        logic keep;
        logic on_wr;
        logic on_rd;
    } wp_kind_t;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } halt_st_e;

    localparam logic [7:0] NO_FREE = 8'hFF;
endpackage

// File: rtl/wpu_entry.sv
module wpu_entry
    import wpu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] wbase_i,
    input  logic [SIZE_W-1:0] wsize_i,
    input  logic [2:0]        wkind_i,
    input  logic              en_i,
    input  logic              bus_valid_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_write_i,
    output logic              range_o,
    output logic              trip_o,
    output logic              autoclr_o,
    output logic              hit_o
);
    localparam int SUM_W = ((ADDR_W > SIZE_W) ? ADDR_W : SIZE_W) + 1;

    logic [ADDR_W-1:0] base_q;
    logic [SIZE_W-1:0] size_q;
    wp_kind_t          kind_q;
    logic              hit_q;
    logic [SUM_W-1:0]  lim;

    assign lim     = SUM_W'(base_q) + SUM_W'(size_q);
    assign range_o = en_i && bus_valid_i && (bus_addr_i >= base_q)
                     && (SUM_W'(bus_addr_i) < lim);
    assign trip_o  = range_o && ((kind_q.on_rd && !bus_write_i)
                                 || (kind_q.on_wr && bus_write_i));
    assign autoclr_o = range_o && !kind_q.keep;
    assign hit_o     = hit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            kind_q <= '0;
            hit_q  <= 1'b0;
        end else if (wr_i) begin
            base_q <= wbase_i;
            size_q <= wsize_i;
            kind_q <= wp_kind_t'(wkind_i);
            hit_q  <= 1'b0;
        end else if (range_o) begin
            hit_q  <= 1'b1;
        end
    end

    // R4
    hit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (range_o && !wr_i) |=> hit_o);

    // R4
    hit_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !hit_o);
endmodule

// File: rtl/wpu_alloc.sv
module wpu_alloc
    import wpu_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] used_i,
    output logic [7:0]   idx_o,
    output logic [N-1:0] onehot_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    always_comb begin
        idx_o    = NO_FREE;
        onehot_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used_i[i]) begin
                idx_o    = 8'(i);
                onehot_o = {{(N-1){1'b0}}, 1'b1} << i;
            end
        end
    end

    // R9
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_o != NO_FREE) |-> !used_i[idx_o[IW-1:0]]);

    // R9
    alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&used_i) |-> (onehot_o == '0));
endmodule

// File: rtl/wpu_halt_fsm.sv
module wpu_halt_fsm
    import wpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic clr_i,
    output logic halt_o
);
    halt_st_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (trip_i) state_d = ST_HALT;
            ST_HALT: if (clr_i && !trip_i) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        halt_o = (state_q == ST_HALT);
    end

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !clr_i) |=> halt_o);

    // R8
    halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> $past(trip_i));
endmodule

// File: rtl/wpu_watch_unit.sv
module wpu_watch_unit
    import wpu_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 16,
    parameter int SIZE_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [$clog2(N)-1:0] cfg_idx,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [SIZE_W-1:0]    cfg_size,
    input  logic [2:0]           cfg_kind,
    input  logic                 en_we,
    input  logic [N-1:0]         en_wdata,
    input  logic                 alloc_req,
    input  logic [ADDR_W-1:0]    alloc_pc,
    output logic [7:0]           alloc_idx_o,
    input  logic                 bus_valid,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_write,
    input  logic                 halt_clr,
    output logic                 halt_o,
    output logic [N-1:0]         en_map_o,
    output logic [N-1:0]         hit_o
);
    localparam int IW = $clog2(N);
    localparam logic [2:0] ALLOC_KIND = 3'b001;
    localparam logic [ADDR_W-1:0] CALL_SKIP = ADDR_W'(3);

    logic [N-1:0] en_q, en_d;
    logic [N-1:0] rng, trip, aclr, free_oh, alloc_oh;
    logic         alloc_go, trip_any;

    wpu_alloc #(.N(N)) u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .used_i   (en_q),
        .idx_o    (alloc_idx_o),
        .onehot_o (free_oh)
    );

    assign alloc_go = alloc_req && (alloc_idx_o != NO_FREE);
    assign alloc_oh = alloc_go ? free_oh : '0;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic              wr;
        logic [ADDR_W-1:0] wbase;
        logic [SIZE_W-1:0] wsize;
        logic [2:0]        wkind;

        assign wr    = alloc_oh[g] || (cfg_we && (cfg_idx == IW'(g)));
        assign wbase = alloc_oh[g] ? (alloc_pc + CALL_SKIP) : cfg_base;
        assign wsize = alloc_oh[g] ? SIZE_W'(1) : cfg_size;
        assign wkind = alloc_oh[g] ? ALLOC_KIND : cfg_kind;

        wpu_entry #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_i        (wr),
            .wbase_i     (wbase),
            .wsize_i     (wsize),
            .wkind_i     (wkind),
            .en_i        (en_q[g]),
            .bus_valid_i (bus_valid),
            .bus_addr_i  (bus_addr),
            .bus_write_i (bus_write),
            .range_o     (rng[g]),
            .trip_o      (trip[g]),
            .autoclr_o   (aclr[g]),
            .hit_o       (hit_o[g])
        );

        // R5
        self_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (aclr[g] && !alloc_oh[g]) |=> !en_map_o[g]);

        // R7
        idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_map_o[g] && !wr) |=> (hit_o[g] == $past(hit_o[g])));
    end

    assign trip_any = |trip;
    assign en_d     = ((en_we ? en_wdata : en_q) & ~aclr) | alloc_oh;

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_map_o = en_q;

    wpu_halt_fsm u_halt (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip_i (trip_any),
        .clr_i  (halt_clr),
        .halt_o (halt_o)
    );

    // R10
    alloc_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_go |=> ((en_q & $past(alloc_oh)) == $past(alloc_oh)));

    // R8
    halt_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip_any |=> halt_o);
endmodule

// File: tb/wpu_watch_unit_bench.sv
module wpu_watch_unit_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 0;
    logic [3:0]  cfg_idx = 0;
    logic [15:0] cfg_base = 0, cfg_size = 0;
    logic [2:0]  cfg_kind = 0;
    logic        en_we = 0;
    logic [15:0] en_wdata = 0;
    logic        alloc_req = 0;
    logic [15:0] alloc_pc = 0;
    logic [7:0]  alloc_idx_o;
    logic        bus_valid = 0, bus_write = 0;
    logic [15:0] bus_addr = 0;
    logic        halt_clr = 0;
    logic        halt_o;
    logic [15:0] en_map_o, hit_o;

    always #4 clk = ~clk;

    wpu_watch_unit u_wpu_watch_unit (.*);

    typedef struct {
        logic        halt;
        logic [15:0] en;
        logic [15:0] hit;
        int          aidx;
        string       tag;
    } item_t;

    item_t q[$];
    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [15:0] m_base[16], m_size[16];
    logic [2:0]  m_kind[16];
    logic [15:0] m_en = 0, m_hit = 0;
    logic        m_halt = 0;

    function automatic int lowfree(logic [15:0] e);
        for (int i = 0; i < 16; i++) if (!e[i]) return i;
        return 255;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        cfg_we = 0; en_we = 0; alloc_req = 0;
        bus_valid = 0; bus_write = 0; halt_clr = 0;
    endtask

    task automatic step(string tag);
        logic [15:0] rng, acl, en_n, hit_n;
        logic trip;
        int a;
        item_t it;
        rng = 0; acl = 0; trip = 0;
        for (int i = 0; i < 16; i++) begin
            if (m_en[i] && bus_valid && ({1'b0, bus_addr} >= {1'b0, m_base[i]})
                && ({1'b0, bus_addr} < ({1'b0, m_base[i]} + {1'b0, m_size[i]}))) begin
                rng[i] = 1;
                if (!m_kind[i][2]) acl[i] = 1;
                if ((m_kind[i][0] && !bus_write) || (m_kind[i][1] && bus_write)) trip = 1;
            end
        end
        a = lowfree(m_en);
        en_n  = (en_we ? en_wdata : m_en) & ~acl;
        hit_n = m_hit | rng;
        if (cfg_we) begin
            m_base[cfg_idx] = cfg_base; m_size[cfg_idx] = cfg_size;
            m_kind[cfg_idx] = cfg_kind; hit_n[cfg_idx] = 0;
        end
        if (alloc_req && a != 255) begin
            en_n[a] = 1; m_base[a] = alloc_pc + 16'd3; m_size[a] = 16'd1;
            m_kind[a] = 3'b001; hit_n[a] = 0;
        end
        m_halt = trip ? 1'b1 : (halt_clr ? 1'b0 : m_halt);
        m_en = en_n; m_hit = hit_n;
        it.halt = m_halt; it.en = m_en; it.hit = m_hit;
        it.aidx = lowfree(m_en); it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        idle();
    endtask

    task automatic cfg(int idx, logic [15:0] b, logic [15:0] s, logic [2:0] k, string tag);
        cfg_we = 1; cfg_idx = 4'(idx); cfg_base = b; cfg_size = s; cfg_kind = k;
        step(tag);
    endtask

    task automatic bus(logic [15:0] a, logic w, string tag);
        bus_valid = 1; bus_addr = a; bus_write = w;
        step(tag);
    endtask

    // monitor: compares one expected item per clock, after the edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                chk(it.tag, "halt", int'(halt_o), int'(it.halt));
                chk(it.tag, "en_map", int'(en_map_o), int'(it.en));
                chk(it.tag, "hit", int'(hit_o), int'(it.hit));
                chk(it.tag, "alloc_idx", int'(alloc_idx_o), it.aidx);
            end
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_size[i] = 0; m_kind[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "halt", int'(halt_o), 0);
        chk("R1", "en_map", int'(en_map_o), 0);
        chk("R1", "hit", int'(hit_o), 0);
        chk("R1", "alloc_idx", int'(alloc_idx_o), 0);

        cfg(0, 16'h1000, 16'h0010, 3'b101, "R4 cfg0");
        cfg(1, 16'h2000, 16'h0004, 3'b010, "R4 cfg1");
        cfg(2, 16'h1008, 16'h0008, 3'b110, "R4 cfg2");
        cfg(3, 16'hFFF0, 16'h0010, 3'b101, "R4 cfg3");
        cfg(4, 16'h4000, 16'h0000, 3'b111, "R4 cfg4");
        en_we = 1; en_wdata = 16'h001F; step("R11 map write");

        bus(16'h1000, 0, "R3 read at base");
        bus(16'h0FFF, 0, "R2 below base");
        halt_clr = 1; step("R8 clear");
        bus(16'h1010, 0, "R2 end exclusive");
        bus(16'h1005, 1, "R4 dir mismatch hit");
        bus(16'h100A, 1, "R6 overlap");
        halt_clr = 1; step("R8 clear2");
        bus(16'h2003, 1, "R5 nonsticky trip");
        halt_clr = 1; bus(16'h2003, 1, "R7 disarmed entry");
        bus(16'hFFFF, 0, "R2 top no wrap");
        halt_clr = 1; bus(16'hFFF5, 0, "R8 set beats clear");
        halt_clr = 1; step("R8 clear3");
        bus(16'h4000, 0, "R2 size zero");

        alloc_pc = 16'h5000; alloc_req = 1; step("R10 alloc");
        bus(16'h5002, 0, "R10 before target");
        bus(16'h5003, 0, "R10 alloc trip");
        halt_clr = 1; step("R8 clear4");

        en_we = 1; en_wdata = 16'hFFFF; step("R9 full");
        alloc_pc = 16'h6000; alloc_req = 1; step("R9 full no effect");
        en_we = 1; en_wdata = 16'h0000; step("R11 clear map");
        bus(16'h1000, 0, "R7 all disarmed");
        cfg(0, 16'h1000, 16'h0010, 3'b001, "R4 rewrite clears hit");
        en_we = 1; en_wdata = 16'h0001; step("R11 arm0");
        en_we = 1; en_wdata = 16'h0001; bus(16'h1000, 0, "R11 disarm beats map write");
        halt_clr = 1; step("R8 clear5");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule